// File: doc/BRIEF.md
# Prescaled Timer Count Core

This block is the counting engine of an event-driven timer. It holds the run-control word for the timer, divides the clock by a programmable prescale value, and advances a counter on each divided tick. Downstream match logic reads the counter value and a per-cycle tick qualifier, and can use a one-cycle limit pulse as an event whenever a counter wraps or turns round.

A configuration input chooses between one 32-bit counter and two independent 16-bit lanes, low and high, that share the 32-bit control word. In split mode the low halfword of the control word drives the low lane and the high halfword drives the high lane, with the same field layout in each half. An auto-limit input makes each lane use its half of the match-0 value as the turning point instead of the all-ones value. Up, down and up/down (triangle) counting are supported. STOP and HALT both freeze the count, while CLEAR is a strobe that zeroes it.

Top module: `tcc_top`

## Requirements
- R1: After reset the count is 0, no limit pulse is raised and the control readback is 0x00040004 (HALT set in both halves, every other field 0).
- R2: The prescale field (bits 12:5 of a half) makes a lane advance once every prescale+1 clocks; a value of 0 advances it on every clock.
- R3: With STOP (bit 1) set the count holds its value; a later write with STOP and HALT both 0 and CLEAR 0 resumes from the held value.
- R4: HALT (bit 2) alone also freezes the count, and the readback shows it set.
- R5: A write with CLEAR (bit 3) set zeroes the count and the prescale divider at that clock edge, taking precedence over counting; CLEAR always reads back as 0.
- R6: Counting up without auto-limit wraps from the all-ones value of the lane width (32 unified, 16 split) to 0.
- R7: With the down bit (bit 0) set and bit 4 clear, the lane decrements and, at 0, reloads its limit value (match half with auto-limit, all-ones without) and raises a limit pulse.
- R8: With auto-limit on, an up-counting lane returns to 0 on the tick after it equals its match-0 value, giving a period of match+1 ticks.
- R9: With bit 4 set the lane counts up from 0 to its limit, then down to 0, then up again; readback bit 0 of the half shows the current direction (1 = down) and a limit pulse marks each turn at the top.
- R10: With the mode input low the low lane follows bits 12:0 and the high lane bits 28:16, match-0 bits 15:0 and 31:16 serve the low and high lanes, and the count output is {high, low}.
- R11: A change of the mode input clears both lanes and sets HALT in both halves at that edge; the count then stays 0.
- R12: limit_o is a registered pulse, high for one cycle in the same cycle the count output first shows the wrapped or turned value.
- R13: tick_o for a lane is high in exactly the cycles at whose closing edge the lane advances; it is 0 while the lane is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_unified | input | 1 | 1 = one 32-bit counter, 0 = two 16-bit lanes |
| cfg_autolim | input | 1 | Use match-0 as the limit value |
| match0 | input | 32 | Match-0 value (split: low half for low lane, high half for high lane) |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback, CLEAR as 0, bit 0 per half as direction |
| count_o | output | 32 | Counter value |
| tick_o | output | 2 | Per-lane advance qualifier (bit 1 = high lane, only in split mode) |
| limit_o | output | 2 | Per-lane one-cycle wrap or turn pulse |

## Verification
The hardest situation to reach from the ports is the interaction of a control write with a counter that is already moving: the edge that applies STOP still advances the count once, and the edge that releases it does not. The stimulus reads the count at the falling edge just before each such write and derives the held value from it, so the scoreboard predicts the exact frozen and resumed sequence. Split mode is reached by a mode switch that must first leave both lanes cleared and halted, after which two lanes with different prescalers and directions run at once, so a mix-up between halves shows in the combined count.

// File: rtl/tcc_pkg.sv
// Shared field positions and the per-lane control record for the count core.
package tcc_pkg;

    localparam int PRE_W    = 8;
    localparam int FLD_W    = 13;
    localparam int B_DOWN   = 0;
    localparam int B_STOP   = 1;
    localparam int B_HALT   = 2;
    localparam int B_CLEAR  = 3;
    localparam int B_BIDIR  = 4;
    localparam int B_PRE_LO = 5;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             bidir;
        logic             halt;
        logic             stop;
        logic             down;
    } lane_ctl_t;

    localparam lane_ctl_t LANE_CTL_RST = '{pre: '0, bidir: 1'b0, halt: 1'b1, stop: 1'b0, down: 1'b0};

    // Extract the stored fields of one control halfword (CLEAR is not stored).
    function automatic lane_ctl_t unpack_ctl(input logic [FLD_W-1:0] f);
        lane_ctl_t r;
        r.pre   = f[B_PRE_LO +: PRE_W];
        r.bidir = f[B_BIDIR];
        r.halt  = f[B_HALT];
        r.stop  = f[B_STOP];
        r.down  = f[B_DOWN];
        return r;
    endfunction

endpackage

// File: rtl/tcc_prescale.sv
// Clock divider for one lane.
// Emits a one-cycle tick every pre_i+1 cycles while run_i is high.
// Assumes clr_i zeroes the divider and suppresses the tick in that cycle.
module tcc_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          clr_i,
    input  logic [PW-1:0] pre_i,
    output logic          tick_o
);

    logic [PW-1:0] div_q;

    // Tick when the divider has reached the prescale value.
    assign tick_o = run_i && !clr_i && (div_q >= pre_i);

    // Advance or restart the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr_i) begin
            div_q <= '0;
        end else if (run_i) begin
            if (div_q >= pre_i) div_q <= '0;
            else                div_q <= div_q + 1'b1;
        end
    end

    // R2: a nonzero prescale never yields ticks on back-to-back cycles.
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && pre_i != '0) |=> (!tick_o || pre_i == '0));

endmodule

// File: rtl/tcc_lane.sv
// One counting lane: prescaler plus an up, down or triangle counter.
// Assumes the limit is at least 1 when triangle counting is used.
// NARROW_W sets the lane width used when narrow_i is high.
module tcc_lane
    import tcc_pkg::*;
#(
    parameter int W        = 32,
    parameter int NARROW_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          narrow_i,
    input  lane_ctl_t     ctl_i,
    input  logic          clr_i,
    input  logic          autolim_i,
    input  logic [W-1:0]  match_i,
    output logic [W-1:0]  cnt_o,
    output logic          tick_o,
    output logic          limit_o,
    output logic          dir_o
);

    localparam logic [W-1:0] FULL       = '1;
    localparam logic [W-1:0] NARROW_TOP = FULL >> (W - NARROW_W);

    logic [W-1:0] cnt_q, nxt, top, lim;
    logic         run, tick, wrap, flip, lim_q, bdir_q;

    assign run = en_i && !ctl_i.stop && !ctl_i.halt;
    assign top = narrow_i ? NARROW_TOP : FULL;
    assign lim = autolim_i ? (match_i & top) : top;

    tcc_prescale #(.PW(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .clr_i  (clr_i),
        .pre_i  (ctl_i.pre),
        .tick_o (tick)
    );

    // Next count value, wrap pulse request and direction flip.
    always_comb begin
        nxt  = cnt_q;
        wrap = 1'b0;
        flip = 1'b0;
        if (ctl_i.bidir) begin
            if (!bdir_q) begin
                if (cnt_q >= lim) begin
                    nxt  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                    flip = 1'b1;
                    wrap = 1'b1;
                end else begin
                    nxt = cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == '0) begin
                    nxt  = (lim == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
                    flip = 1'b1;
                end else begin
                    nxt = cnt_q - 1'b1;
                end
            end
        end else if (ctl_i.down) begin
            if (cnt_q == '0) begin
                nxt  = lim;
                wrap = 1'b1;
            end else begin
                nxt = (cnt_q - 1'b1) & top;
            end
        end else begin
            if (cnt_q == lim) begin
                nxt  = '0;
                wrap = 1'b1;
            end else begin
                nxt = (cnt_q + 1'b1) & top;
            end
        end
    end

    // Count, limit pulse and triangle direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= 1'b0;
            bdir_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q  <= '0;
            lim_q  <= 1'b0;
            bdir_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= nxt;
            lim_q  <= wrap;
            if (flip) bdir_q <= ~bdir_q;
        end else begin
            lim_q  <= 1'b0;
        end
    end

    assign cnt_o   = cnt_q;
    assign tick_o  = tick;
    assign limit_o = lim_q;
    assign dir_o   = ctl_i.bidir ? bdir_q : ctl_i.down;

    // R3, R4: a frozen lane keeps its count.
    a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_i) |=> $stable(cnt_q));

    // R8: auto-limit returns an up counter to zero after equality.
    a_r8_autolimit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && autolim_i && !ctl_i.bidir && !ctl_i.down && cnt_q == lim) |=> (cnt_q == '0));

    // R12: in plain up counting the pulse coincides with the zero count.
    a_r12_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_o && $stable(ctl_i) && !ctl_i.bidir && !ctl_i.down) |-> (cnt_q == '0));

    // R13: no tick while the lane is frozen.
    a_r13_no_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick_o);

endmodule

// File: rtl/tcc_ctl.sv
// Control word store for both lanes.
// Unified mode writes only the low half; split mode writes both halves.
// A change of the mode input sets HALT in both halves and clears both lanes.
module tcc_ctl
    import tcc_pkg::*;
#(
    parameter int DW     = 32,
    parameter int HALF_W = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unified_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output lane_ctl_t     ctl_lo_o,
    output lane_ctl_t     ctl_hi_o,
    output logic          clr_lo_o,
    output logic          clr_hi_o
);

    lane_ctl_t   lo_q, hi_q;
    logic        uni_q, chg, wr_hi;
    logic        unused_wbits;

    assign chg          = unified_i ^ uni_q;
    assign wr_hi        = wr_i && !unified_i;
    assign clr_lo_o     = chg || (wr_i && wdata_i[B_CLEAR]);
    assign clr_hi_o     = chg || (wr_hi && wdata_i[HALF_W + B_CLEAR]);
    assign unused_wbits = ^{wdata_i[HALF_W-1:FLD_W], wdata_i[DW-1:HALF_W+FLD_W]};

    // Hold the control fields and track the mode input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= LANE_CTL_RST;
            hi_q  <= LANE_CTL_RST;
            uni_q <= unified_i;
        end else begin
            uni_q <= unified_i;
            if (chg) begin
                lo_q.halt <= 1'b1;
                hi_q.halt <= 1'b1;
            end else begin
                if (wr_i)  lo_q <= unpack_ctl(wdata_i[FLD_W-1:0]);
                if (wr_hi) hi_q <= unpack_ctl(wdata_i[HALF_W +: FLD_W]);
            end
        end
    end

    assign ctl_lo_o = lo_q;
    assign ctl_hi_o = hi_q;

    // R11: a mode change leaves both halves halted.
    a_r11_halt_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (lo_q.halt && hi_q.halt));

endmodule

// File: rtl/tcc_top.sv
// Timer count core: control word, two prescaled lanes and mode muxing.
// Unified mode uses the low lane at full width; split mode narrows it
// to HALF_W and enables the high lane.
module tcc_top
    import tcc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_unified,
    input  logic              cfg_autolim,
    input  logic [CNT_W-1:0]  match0,
    input  logic              ctl_wr,
    input  logic [CNT_W-1:0]  ctl_wdata,
    output logic [CNT_W-1:0]  ctl_rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic [1:0]        tick_o,
    output logic [1:0]        limit_o
);

    localparam int HALF_W = CNT_W / 2;
    localparam int PAD_W  = HALF_W - FLD_W;

    lane_ctl_t          ctl_lo, ctl_hi;
    logic               clr_lo, clr_hi;
    logic [CNT_W-1:0]   cnt_lo;
    logic [HALF_W-1:0]  cnt_hi;
    logic               dir_lo, dir_hi;

    tcc_ctl #(.DW(CNT_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .unified_i (cfg_unified),
        .wr_i      (ctl_wr),
        .wdata_i   (ctl_wdata),
        .ctl_lo_o  (ctl_lo),
        .ctl_hi_o  (ctl_hi),
        .clr_lo_o  (clr_lo),
        .clr_hi_o  (clr_hi)
    );

    tcc_lane #(.W(CNT_W), .NARROW_W(HALF_W)) u_lane_lo (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (1'b1),
        .narrow_i  (!cfg_unified),
        .ctl_i     (ctl_lo),
        .clr_i     (clr_lo),
        .autolim_i (cfg_autolim),
        .match_i   (match0),
        .cnt_o     (cnt_lo),
        .tick_o    (tick_o[0]),
        .limit_o   (limit_o[0]),
        .dir_o     (dir_lo)
    );

    tcc_lane #(.W(HALF_W), .NARROW_W(HALF_W)) u_lane_hi (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (!cfg_unified),
        .narrow_i  (1'b1),
        .ctl_i     (ctl_hi),
        .clr_i     (clr_hi),
        .autolim_i (cfg_autolim),
        .match_i   (match0[CNT_W-1:HALF_W]),
        .cnt_o     (cnt_hi),
        .tick_o    (tick_o[1]),
        .limit_o   (limit_o[1]),
        .dir_o     (dir_hi)
    );

    // Select the visible count for the current mode.
    always_comb begin
        if (cfg_unified) count_o = cnt_lo;
        else             count_o = {cnt_hi, cnt_lo[HALF_W-1:0]};
    end

    // Rebuild the readback word; CLEAR reads as zero, bit 0 shows direction.
    always_comb begin
        ctl_rdata = {{PAD_W{1'b0}}, ctl_hi.pre, ctl_hi.bidir, 1'b0, ctl_hi.halt, ctl_hi.stop, dir_hi,
                     {PAD_W{1'b0}}, ctl_lo.pre, ctl_lo.bidir, 1'b0, ctl_lo.halt, ctl_lo.stop, dir_lo};
    end

    // R5: a clear strobe zeroes the low lane at the next edge.
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[B_CLEAR]) |=> (count_o[HALF_W-1:0] == '0));

    // R11: after a mode change the count reads zero.
    a_r11_switch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unified != $past(cfg_unified)) |=> (count_o == '0));

endmodule

// File: tb/tcc_top_tb_top.sv
module tcc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_unified = 1'b1;
    logic        cfg_autolim = 1'b0;
    logic [31:0] match0 = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata, count_o;
    logic [1:0]  tick_o, limit_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] q_cnt[$];
    logic [1:0]  q_lim[$];
    logic        q_dir[$];
    string       q_req[$];

    always #5 clk = ~clk;

    tcc_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_unified(cfg_unified), .cfg_autolim(cfg_autolim),
        .match0(match0), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .count_o(count_o), .tick_o(tick_o), .limit_o(limit_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected state k edges after the write edge of a phase.
    task automatic expect_of(input int mode, input int k, input logic [31:0] base,
                             output logic [31:0] c, output logic [1:0] l, output logic d);
        int m;
        c = '0; l = 2'b00; d = 1'b0;
        case (mode)
            0: c = k;
            1: c = k / 3;
            2: begin c = k % 5; l[0] = (k > 0) && (k % 5 == 0); end
            3: c = base + 1;
            4: c = base + k;
            5: c = base + 1;
            6: c = '0;
            7: begin
                d = 1'b1;
                c = (k == 0) ? 0 : 3 - ((k - 1) % 4);
                l[0] = (k % 4 == 1);
            end
            8: begin
                d = 1'b1;
                c = (k == 0) ? 32'h0 : 32'hFFFF_FFFF - (k - 1);
                l[0] = (k == 1);
            end
            9: begin
                m = k % 6;
                c = (m <= 3) ? m : 6 - m;
                l[0] = (m == 4);
                d = (m >= 4) || (m == 0 && k > 0);
            end
            10: begin
                d = 1'b1;
                c[15:0]  = (k == 0) ? 16'h0 : 16'(32'h10000 - k);
                c[31:16] = 16'(k / 2);
                l[0] = (k == 1);
            end
            11: begin
                c[15:0]  = 16'(k % 4);
                c[31:16] = 16'((k / 2) % 6);
                l[0] = (k > 0) && (k % 4 == 0);
                l[1] = (k > 0) && (k % 2 == 0) && ((k / 2) % 6 == 0);
            end
            default: c = '0;
        endcase
    endtask

    task automatic push_items(input int mode, input int n, input logic [31:0] base, input string req);
        logic [31:0] c; logic [1:0] l; logic d;
        for (int k = 0; k < n; k++) begin
            expect_of(mode, k, base, c, l, d);
            q_cnt.push_back(c); q_lim.push_back(l); q_dir.push_back(d); q_req.push_back(req);
        end
    endtask

    task automatic drain();
        while (q_cnt.size() > 0) @(negedge clk);
    endtask

    // Driver: write a control word and queue the predicted sequence.
    task automatic run_phase(input int mode, input logic [31:0] word, input logic al,
                             input logic [31:0] m0, input int n, input string req);
        logic [31:0] base;
        @(negedge clk);
        base = count_o;
        cfg_autolim = al; match0 = m0;
        ctl_wr = 1'b1; ctl_wdata = word;
        @(posedge clk);
        push_items(mode, n, base, req);
        @(negedge clk);
        ctl_wr = 1'b0;
        drain();
    endtask

    // Driver: flip the mode input and expect a cleared, frozen count.
    task automatic switch_mode(input logic uni, input int n);
        @(negedge clk);
        cfg_unified = uni;
        @(posedge clk);
        push_items(6, n, '0, "R11");
        drain();
    endtask

    // Monitor: compare queued predictions away from the clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_cnt.size() > 0) begin
                logic [31:0] ec; logic [1:0] el; logic ed; string r;
                ec = q_cnt.pop_front(); el = q_lim.pop_front();
                ed = q_dir.pop_front(); r = q_req.pop_front();
                check(count_o === ec, r, "count", count_o, ec);
                check(limit_o === el, {r, " R12"}, "limit", {30'b0, limit_o}, {30'b0, el});
                check(ctl_rdata[0] === ed, r, "direction", {31'b0, ctl_rdata[0]}, {31'b0, ed});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(count_o === 32'h0, "R1", "count", count_o, 32'h0);
        check(ctl_rdata === 32'h0004_0004, "R1", "readback", ctl_rdata, 32'h0004_0004);
        check(limit_o === 2'b00, "R1", "limit", {30'b0, limit_o}, 32'h0);

        run_phase(0, 32'h0000_0008, 1'b0, 32'h0, 12, "R6");
        check(tick_o === 2'b01, "R13", "tick running", {30'b0, tick_o}, 32'h1);
        run_phase(3, 32'h0000_0002, 1'b0, 32'h0, 6, "R3");
        check(tick_o === 2'b00, "R13", "tick stopped", {30'b0, tick_o}, 32'h0);
        run_phase(4, 32'h0000_0000, 1'b0, 32'h0, 8, "R3");
        run_phase(5, 32'h0000_0004, 1'b0, 32'h0, 6, "R4");
        check(ctl_rdata[2] === 1'b1, "R4", "halt readback", {31'b0, ctl_rdata[2]}, 32'h1);
        run_phase(6, 32'h0000_000E, 1'b0, 32'h0, 5, "R5");
        check(ctl_rdata === 32'h0004_0006, "R5", "clear reads zero", ctl_rdata, 32'h0004_0006);
        run_phase(1, 32'h0000_0048, 1'b0, 32'h0, 16, "R2");
        run_phase(2, 32'h0000_0008, 1'b1, 32'h4, 16, "R8");
        run_phase(7, 32'h0000_0009, 1'b1, 32'h3, 12, "R7");
        run_phase(8, 32'h0000_0009, 1'b0, 32'h0, 6, "R7 R6");
        run_phase(9, 32'h0000_0018, 1'b1, 32'h3, 20, "R9");

        switch_mode(1'b0, 4);
        check(ctl_rdata === 32'h0004_0014, "R11", "halt both halves", ctl_rdata, 32'h0004_0014);
        run_phase(10, 32'h0028_0009, 1'b0, 32'h0, 10, "R10 R2");
        run_phase(11, 32'h0028_0008, 1'b1, 32'h0005_0003, 26, "R10 R8");
        switch_mode(1'b1, 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule